// File: doc/BRIEF.md
# General-Purpose I/O Port with Input Pullups

This block is one byte-wide general-purpose I/O port for a small microcontroller bus. Software reaches three registers through a simple read/write register interface. The data latch holds the value each pin drives. The direction register chooses input or output for each pin. The pullup register connects a weak internal pullup on each of the seven lower pins. Toward the pad the block drives an output value, an output enable and a pullup enable for every pin. It also samples the pad level through a two-stage synchroniser.

A pin can be handed to a peripheral such as a timer channel or a serial unit. Each pin has a two-bit ownership field, driven from outside the block. While that field is nonzero, the peripheral's output value and output enable replace the latch bit and the direction bit. The pullup is cut off whenever the final output enable of a pin is active. Reset clears the direction and pullup registers. It leaves the data latch unchanged.

Top module: `gpio_pullup_port`

## Requirements
- R1: On reset, the direction and pullup registers clear to zero. After reset every pin is an input (`pad_oe`=0), no pullup is connected (`pad_pu`=0), and both registers read back as 0.
- R2: A write with `wr_en`=1 takes effect at the rising clock edge that samples it. Address 1 is the direction register: bit value 1 means output, 0 means input. A read of address 1 returns the stored value.
- R3: Address 2 is the pullup register. Only bits 0 to 6 exist. Bit 7 always reads 0, and writing it has no effect.
- R4: `pad_pu[i]` is 1 only when pullup bit i is 1 and pin i is not driving. A pin whose final output enable is 1 never has its pullup on, whatever its pullup bit holds.
- R5: Reset does not change the data latch (address 0). A value written before reset reads back unchanged after reset once the pin is set as an output.
- R6: A read of address 0 returns, for each pin, the latch bit if its direction bit is 1, and otherwise the synchronised pad level. A change on `pad_in` appears in the read data after exactly two rising edges.
- R7: For a pin with no owning peripheral, `pad_out` equals the latch bit and `pad_oe` equals the direction bit.
- R8: The ownership field for pin i is `alt_sel[2i+1:2i]`. When the field is nonzero, `pad_out[i]`=`alt_out[i]` and `pad_oe[i]`=`alt_oe[i]`. When the field is zero, the pin returns to general-purpose control.
- R9: Address 3 is not mapped. Reading it returns 0, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address (0 data, 1 direction, 2 pullup) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `addr` |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Output enable to the pads |
| pad_pu | output | 8 | Pullup enable to the pads |
| alt_sel | input | 16 | Per-pin peripheral ownership fields |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |

## Verification
Two functions can act in the same cycle: pullup gating and peripheral ownership. A pullup register write can land at the very edge where a peripheral takes a pin and asserts its output enable. The bench changes the ownership field and writes the pullup register in the same cycle. It then checks that the owned, driving pin shows no pullup while its neighbours do. It also checks that releasing ownership brings the pin's pullup back. The read-back path is tested the same way, by watching the exact edge on which a pad change reaches the read data.

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port #(
  parameter int NPINS   = 8,
  parameter int PU_PINS = 7,
  parameter int ADDR_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NPINS-1:0]     wr_data,
  output logic [NPINS-1:0]     rd_data,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_pu,
  input  logic [2*NPINS-1:0]   alt_sel,
  input  logic [NPINS-1:0]     alt_out,
  input  logic [NPINS-1:0]     alt_oe
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(2);

  logic [NPINS-1:0]   lat_q, ddr_q, sync1_q, sync2_q, owned, pu_full;
  logic [PU_PINS-1:0] pue_q;

  always_ff @(posedge clk)
    if (wr_en && addr == A_DATA) lat_q <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q <= '0;
      pue_q <= '0;
    end else if (wr_en) begin
      if (addr == A_DIR) ddr_q <= wr_data;
      if (addr == A_PU)  pue_q <= wr_data[PU_PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    pu_full = '0;
    pu_full[PU_PINS-1:0] = pue_q;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign owned[i]   = |alt_sel[2*i+1:2*i];
    assign pad_out[i] = owned[i] ? alt_out[i] : lat_q[i];
    assign pad_oe[i]  = owned[i] ? alt_oe[i]  : ddr_q[i];
    assign pad_pu[i]  = pu_full[i] & ~pad_oe[i];
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_data = (lat_q & ddr_q) | (sync2_q & ~ddr_q);
      A_DIR:   rd_data = ddr_q;
      A_PU:    rd_data = pu_full;
      default: rd_data = '0;
    endcase
  end

  // R4
  pu_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> ddr_q == $past(wr_data));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DATA) |=> $stable(lat_q));

  // R8
  gpio_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel == '0) |-> (pad_oe == ddr_q && pad_out == lat_q));

endmodule

// File: tb/gpio_pullup_port_tb.sv
module gpio_pullup_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wr_data = 0, pad_in = 0, alt_out = 0, alt_oe = 0;
  logic [15:0] alt_sel = 0;
  logic [7:0]  rd_data, pad_out, pad_oe, pad_pu;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pullup_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5 d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
    rd(2'd1, d); check("R1 dir", d, 8'h00);
    rd(2'd2, d); check("R1 pue", d, 8'h00);
  endtask

  task automatic t_dir_data();
    logic [7:0] d;
    wr(2'd1, 8'hA5);
    check("R2 oe", pad_oe, 8'hA5);
    rd(2'd1, d); check("R2 dir read", d, 8'hA5);
    wr(2'd0, 8'h3C);
    check("R7 out", pad_out, 8'h3C);
    check("R7 oe", pad_oe, 8'hA5);
  endtask

  task automatic t_pullup();
    logic [7:0] d;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R3 bit7", d, 8'h7F);
    check("R4 mixed", pad_pu, 8'h70);
    wr(2'd1, 8'h00); check("R4 inputs", pad_pu, 8'h7F);
    wr(2'd1, 8'hFF); check("R4 outputs", pad_pu, 8'h00);
  endtask

  task automatic t_read_mix();
    logic [7:0] d;
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hA5);
    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); check("R6 mix", d, 8'hAC);
    pad_in = 8'hC3;
    @(negedge clk);
    rd(2'd0, d); check("R6 one edge", d, 8'hAC);
    @(negedge clk);
    rd(2'd0, d); check("R6 two edges", d, 8'hA3);
  endtask

  task automatic t_latch_reset();
    logic [7:0] d;
    wr(2'd0, 8'h5A);
    do_reset();
    check("R1 oe again", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd0, d); check("R5 latch kept", d, 8'h5A);
    check("R5 pad_out", pad_out, 8'h5A);
  endtask

  task automatic t_alt();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    @(negedge clk);
    alt_sel = 16'hC100; alt_out = 8'hFF; alt_oe = 8'h10;
    wr_en = 1; addr = 2'd2; wr_data = 8'h7F;
    @(negedge clk); wr_en = 0;
    check("R8 oe", pad_oe, 8'h10);
    check("R8 out", pad_out, 8'h90);
    check("R4 owned pu", pad_pu, 8'h6F);
    alt_sel = 16'hC000; #0.5;
    check("R8 release oe", pad_oe, 8'h00);
    check("R8 release pu", pad_pu, 8'h7F);
    alt_sel = 0; alt_oe = 0; alt_out = 0;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(2'd1, 8'h33);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R9 read", d, 8'h00);
    rd(2'd1, d); check("R9 dir kept", d, 8'h33);
    rd(2'd2, d); check("R9 pue kept", d, 8'h7F);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_dir_data();
    t_pullup();
    t_read_mix();
    t_latch_reset();
    t_alt();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule